// File: doc/BRIEF.md
# DMA Page Register Bank

This block holds the upper address bits that eight DMA channels use. Software reaches it through a 16-location byte window, addressed by a 4-bit offset. Eight of the locations are channel page registers. They follow a fixed, irregular assignment from offset to channel, and each one drives a page output bus. The remaining eight locations are plain scratch bytes with no effect on any channel.

Every write, to any offset, is also recorded in a 16-byte shadow store. Two static configuration inputs decide what reads return. One enables read-back of the scratch locations; when it is off, those locations read as all ones. The other makes the whole bank write-only, so that every read returns all ones while writes still take effect. Read data depends only on the current address and state, and it is valid in the same cycle as the read strobe.

Top module: `dma_page_bank`

## Requirements
- R1: While rst_n is low at a rising clock edge, every channel page register and every shadow byte clears to 0x00. After reset, all page outputs are zero, and a scratch read with read-back enabled returns 0x00.
- R2: Channel page registers sit at fixed offsets: channel 0 at 0x7, channel 1 at 0x3, channel 2 at 0x1, channel 3 at 0x2, channel 4 at 0xF, channel 5 at 0xB, channel 6 at 0x9 and channel 7 at 0xA. Channel n drives page_out bits [8n+7:8n].
- R3: A write (io_wr high at a rising edge) to a channel offset loads io_wdata into that channel's page register, visible on page_out after that edge. No other channel changes.
- R4: A write to any of the scratch offsets 0x0, 0x4, 0x5, 0x6, 0x8, 0xC, 0xD and 0xE leaves all page outputs unchanged.
- R5: With write-only mode off, a read at a channel offset returns that channel's current page value, whatever the scratch read-back setting is.
- R6: With write-only mode off and scratch read-back on, a read at a scratch offset returns the last byte written there.
- R7: With write-only mode off and scratch read-back off, a read at a scratch offset returns 0xFF.
- R8: With write-only mode on, every read returns 0xFF. Writes still update the page registers and the shadow store.
- R9: A scratch write is stored even while read-back is disabled or write-only mode is on. It becomes readable once both settings allow it.
- R10: io_rdata is combinational from io_addr and the stored state, and is valid in the cycle io_rd is high. When io_wr is low at an edge, no stored value changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 4 | Offset within the 16-byte window |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Write strobe, sampled at the rising edge |
| io_rd | input | 1 | Read strobe, qualifies io_rdata |
| io_rdata | output | 8 | Read data, same cycle |
| cfg_scratch_rd_en | input | 1 | Enables read-back of scratch offsets |
| cfg_wr_only | input | 1 | Makes every read return all ones |
| page_out | output | 64 | Eight channel pages, channel n in bits [8n+7:8n] |

## Verification
The bench writes a distinct byte to each channel offset and then reads every page output. This exposes a design that swaps two channels in the irregular map, or that treats the offsets as linear, because a wrong channel would show another channel's byte. Scratch writes are made while read-back is disabled and while write-only mode is on, and then read back once both settings allow it. A design that gated storage on the read configuration would return zero or stale data there. Reads at every offset are tried under all four configuration combinations, to catch a mux that lets write-only mode lose to the channel path, or that masks channel reads when scratch read-back is off. Random traffic is compared against a bench model after every write, to catch stray updates to neighbouring registers.

// File: rtl/dma_page_pkg.sv
// Package: shared sizes and the offset map for the page register bank.
// Assumes exactly eight channels in two groups of four.
package dma_page_pkg;
    localparam int unsigned PG_DATA_W = 8;
    localparam int unsigned PG_ADDR_W = 4;
    localparam int unsigned PG_DEPTH  = 1 << PG_ADDR_W;
    localparam int unsigned PG_NUM_CH = 8;
    localparam int unsigned PG_CH_W   = $clog2(PG_NUM_CH);

    // Offset of the page register that belongs to channel ch.
    // Each group of four uses slots 7,3,1,2; the upper group adds 8.
    function automatic logic [PG_ADDR_W-1:0] chan_offset(input int unsigned ch);
        logic [PG_ADDR_W-1:0] slot;
        case (ch % 4)
            0:       slot = 4'h7;
            1:       slot = 4'h3;
            2:       slot = 4'h1;
            default: slot = 4'h2;
        endcase
        if (ch >= 4) slot = slot | 4'h8;
        return slot;
    endfunction
endpackage

// File: rtl/page_addr_decode.sv
// Module: page_addr_decode
// Turns an offset into a one-hot channel hit vector and a binary channel index.
// Assumes the offset map from dma_page_pkg; purely combinational.
module page_addr_decode
    import dma_page_pkg::*;
#(
    parameter int unsigned ADDR_W = PG_ADDR_W,
    parameter int unsigned NUM_CH = PG_NUM_CH,
    localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NUM_CH-1:0] hit,
    output logic              is_chan,
    output logic [CH_W-1:0]   chan_idx
);
    // one comparator per channel against its fixed offset
    for (genvar c = 0; c < NUM_CH; c++) begin : g_cmp
        assign hit[c] = (addr == ADDR_W'(chan_offset(c)));
    end

    // any channel offset selected
    assign is_chan = |hit;

    // binary index of the selected channel (offsets are unique)
    always_comb begin
        chan_idx = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (hit[c]) chan_idx = CH_W'(c);
        end
    end
endmodule

// File: rtl/page_shadow_regs.sv
// Module: page_shadow_regs
// Sixteen-byte store that records every write by offset.
// Assumes a synchronous active-low reset; read is an unregistered select.
module page_shadow_regs #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 4,
    localparam int unsigned DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    // store write data at the addressed entry, clear all on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (wr_en) begin
            mem_q[addr] <= wdata;
        end
    end

    // select the addressed entry
    assign rdata = mem_q[addr];
endmodule

// File: rtl/page_channel_regs.sv
// Module: page_channel_regs
// One page register per channel, loaded when its decode hit is set during a write.
// Assumes hit is one-hot or zero.
module page_channel_regs #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned NUM_CH = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [NUM_CH-1:0]        hit,
    input  logic [DATA_W-1:0]        wdata,
    output logic [NUM_CH*DATA_W-1:0] pages
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [DATA_W-1:0] page_q;

        // load this channel's page on a matching write
        always_ff @(posedge clk) begin
            if (!rst_n)                page_q <= '0;
            else if (wr_en && hit[c])  page_q <= wdata;
        end

        assign pages[c*DATA_W +: DATA_W] = page_q;
    end
endmodule

// File: rtl/page_read_mux.sv
// Module: page_read_mux
// Picks read data from the channel page, the shadow byte or all ones.
// Assumes the configuration inputs are quasi-static.
module page_read_mux #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned NUM_CH = 8,
    localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
    input  logic [NUM_CH*DATA_W-1:0] pages,
    input  logic [DATA_W-1:0]        shadow_byte,
    input  logic                     is_chan,
    input  logic [CH_W-1:0]          chan_idx,
    input  logic                     scratch_rd_en,
    input  logic                     wr_only,
    output logic [DATA_W-1:0]        rdata
);
    // priority: write-only, channel page, scratch byte, all ones
    always_comb begin
        if (wr_only)            rdata = '1;
        else if (is_chan)       rdata = pages[chan_idx*DATA_W +: DATA_W];
        else if (scratch_rd_en) rdata = shadow_byte;
        else                    rdata = '1;
    end
endmodule

// File: rtl/dma_page_bank.sv
// Module: dma_page_bank (top)
// I/O-mapped bank of page registers for eight DMA channels plus scratch bytes.
// Assumes one write per cycle; read data is combinational.
module dma_page_bank
    import dma_page_pkg::*;
#(
    parameter int unsigned DATA_W = PG_DATA_W,
    parameter int unsigned ADDR_W = PG_ADDR_W,
    parameter int unsigned NUM_CH = PG_NUM_CH,
    localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        io_addr,
    input  logic [DATA_W-1:0]        io_wdata,
    input  logic                     io_wr,
    input  logic                     io_rd,
    output logic [DATA_W-1:0]        io_rdata,
    input  logic                     cfg_scratch_rd_en,
    input  logic                     cfg_wr_only,
    output logic [NUM_CH*DATA_W-1:0] page_out
);
    logic [NUM_CH-1:0] hit;
    logic              is_chan;
    logic [CH_W-1:0]   chan_idx;
    logic [DATA_W-1:0] shadow_byte;
    logic [DATA_W-1:0] mux_data;

    page_addr_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_dec (
        .addr(io_addr), .hit(hit), .is_chan(is_chan), .chan_idx(chan_idx)
    );

    page_shadow_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_shadow (
        .clk(clk), .rst_n(rst_n), .wr_en(io_wr), .addr(io_addr),
        .wdata(io_wdata), .rdata(shadow_byte)
    );

    page_channel_regs #(.DATA_W(DATA_W), .NUM_CH(NUM_CH)) u_chan (
        .clk(clk), .rst_n(rst_n), .wr_en(io_wr), .hit(hit),
        .wdata(io_wdata), .pages(page_out)
    );

    page_read_mux #(.DATA_W(DATA_W), .NUM_CH(NUM_CH)) u_rmux (
        .pages(page_out), .shadow_byte(shadow_byte), .is_chan(is_chan),
        .chan_idx(chan_idx), .scratch_rd_en(cfg_scratch_rd_en),
        .wr_only(cfg_wr_only), .rdata(mux_data)
    );

    // read data is qualified by io_rd at the consumer; drive it unconditionally
    assign io_rdata = mux_data;

    logic unused_rd;
    assign unused_rd = io_rd;
endmodule

// File: rtl/dma_page_bank_chk.sv
// Module: dma_page_bank_chk
// Port-level properties of the page register bank, bound to the top module.
module dma_page_bank_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  io_addr,
    input logic [7:0]  io_wdata,
    input logic        io_wr,
    input logic [7:0]  io_rdata,
    input logic        cfg_scratch_rd_en,
    input logic        cfg_wr_only,
    input logic [63:0] page_out
);
    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> page_out == 64'h0);

    // R3
    ch0_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == 4'h7) |=> page_out[7:0] == $past(io_wdata));

    // R4
    scratch_no_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == 4'h0) |=> $stable(page_out));

    // R10
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !io_wr |=> $stable(page_out));

    // R8
    wr_only_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_only |-> io_rdata == 8'hFF);

    // R7
    scratch_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_wr_only && !cfg_scratch_rd_en && io_addr == 4'h4) |-> io_rdata == 8'hFF);
endmodule

bind dma_page_bank dma_page_bank_chk u_chk (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_wr(io_wr), .io_rdata(io_rdata), .cfg_scratch_rd_en(cfg_scratch_rd_en),
    .cfg_wr_only(cfg_wr_only), .page_out(page_out)
);

// File: tb/sim_dma_page_bank.sv
module sim_dma_page_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_rdata;
    logic        cfg_scratch_rd_en = 1'b1;
    logic        cfg_wr_only = 1'b0;
    logic [63:0] page_out;

    int tests = 0;
    int fails = 0;
    logic [7:0] model [16];
    bit done = 1'b0;

    always #2 clk = ~clk;

    dma_page_bank u0 (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata),
        .cfg_scratch_rd_en(cfg_scratch_rd_en), .cfg_wr_only(cfg_wr_only),
        .page_out(page_out)
    );

    // channel -> offset, from R2
    function automatic logic [3:0] exp_off(input int ch);
        logic [3:0] t [8] = '{4'h7, 4'h3, 4'h1, 4'h2, 4'hF, 4'hB, 4'h9, 4'hA};
        return t[ch];
    endfunction

    function automatic bit is_chan_off(input logic [3:0] a);
        for (int c = 0; c < 8; c++) if (exp_off(c) == a) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [7:0] exp_read(input logic [3:0] a);
        if (cfg_wr_only) return 8'hFF;
        if (is_chan_off(a)) return model[a];
        if (cfg_scratch_rd_en) return model[a];
        return 8'hFF;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
        model[a] = d;
    endtask

    task automatic rd_check(input string req, input logic [3:0] a);
        io_addr = a; io_rd = 1'b1;
        #1;
        check(req, {56'h0, io_rdata}, {56'h0, exp_read(a)});
        io_rd = 1'b0;
    endtask

    task automatic pages_check(input string req);
        logic [63:0] e;
        for (int c = 0; c < 8; c++) e[c*8 +: 8] = model[exp_off(c)];
        check(req, page_out, e);
    endtask

    initial begin
        int unsigned seed_val;
        seed_val = $urandom(32'd1234);
        for (int i = 0; i < 16; i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 pages", page_out, 64'h0);
        rd_check("R1 scratch read", 4'h5);

        // R2 R3 distinct byte per channel
        for (int c = 0; c < 8; c++) wr(exp_off(c), 8'h10 + 8'(c) * 8'h11);
        pages_check("R2 R3 channel map");
        // R5 read each channel offset, scratch read-back off
        cfg_scratch_rd_en = 1'b0;
        for (int c = 0; c < 8; c++) rd_check("R5 channel read", exp_off(c));
        // R7 scratch hidden
        rd_check("R7 scratch hidden", 4'h0);
        rd_check("R7 scratch hidden", 4'hE);
        // R4 R9 scratch write while hidden
        wr(4'h6, 8'hA5);
        wr(4'hC, 8'h3C);
        pages_check("R4 scratch no page effect");
        rd_check("R7 still hidden", 4'h6);
        // R8 write-only: all ones, writes still land
        cfg_wr_only = 1'b1;
        rd_check("R8 ones channel", 4'h7);
        rd_check("R8 ones scratch", 4'h6);
        wr(4'hB, 8'h5B);
        wr(4'hD, 8'hD7);
        pages_check("R8 write lands");
        // R9 scratch visible once allowed
        cfg_wr_only = 1'b0;
        cfg_scratch_rd_en = 1'b1;
        rd_check("R9 stored while hidden", 4'h6);
        rd_check("R9 stored in wr_only", 4'hD);
        rd_check("R6 scratch read", 4'hC);
        // R10 strobe low: no change
        @(negedge clk);
        io_addr = 4'h7; io_wdata = 8'hEE; io_wr = 1'b0;
        @(negedge clk);
        pages_check("R10 no write without strobe");
        rd_check("R10 same-cycle read", 4'h7);

        // random traffic
        for (int n = 0; n < 400; n++) begin
            logic [3:0] a;
            a = 4'($urandom);
            cfg_wr_only = ($urandom % 4) == 0;
            cfg_scratch_rd_en = $urandom % 2;
            wr(a, 8'($urandom));
            pages_check("R3 R4 random pages");
            rd_check("R5 R6 R7 R8 random read", 4'($urandom));
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                tests++; fails++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule